// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block drives the column side of one burst access to a four-bank SDRAM with a 64-bit word. A controller that has already opened a row sends a start request with a bank, a start column and a direction. From the next cycle on, the sequencer presents one column address per clock. For write beats it raises a write-data strobe. For read beats it raises a read-data-valid flag once the programmed CAS latency has passed. A stop input cuts a burst short. A full-page burst can end in no other way.

A small mode register holds the burst length, the burst ordering, the CAS latency and the write-burst policy. It accepts a new setting only while the sequencer is quiet, meaning no beat is being issued and no read data is still due. A request pin carries a command, not a stream of data, so it has no back-pressure. Every request is taken on the edge that samples it, and a new request replaces any burst already running. All inputs are sampled on the rising clock edge, and all outputs change there.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset no beat is issued, `rd_valid`, `wr_strobe`, `busy` and `mode_err` are low, and the mode is burst of 4, sequential, CAS latency 3, full-length writes.
- R2: A request sampled on an edge makes the next cycle carry beat 0, with `col_valid` high, `col_addr` equal to the start column and `col_bank` equal to the requested bank. Each later cycle carries one further beat.
- R3: With `mode_bl` 2'b00 (4 beats) or 2'b01 (8 beats) and `mode_ilv` low, the low 2 or 3 column bits count up from the start column and wrap inside the aligned block. The upper bits stay fixed, and the burst ends after 4 or 8 beats.
- R4: With `mode_ilv` high and a length of 4 or 8, beat k carries the start column with its low 2 or 3 bits XORed with k.
- R5: With `mode_bl[1]` set (full page), beat k carries (start + k) modulo 256. `mode_ilv` has no effect. The burst runs until stopped.
- R6: A `stop` sampled during a burst removes every beat from the next cycle on. A `stop` sampled together with a request has no effect, and the new burst starts.
- R7: `rd_valid` is high exactly CAS latency cycles after each read beat's cycle. The latency is 3 when `mode_cl3` is 1 and 2 when it is 0. A stopped read therefore loses its trailing valid flags with the same delay.
- R8: `wr_strobe` is high in the cycle of every write beat and never for a read beat. With `mode_wsingle` high, a write burst is one beat long, while reads keep the programmed length.
- R9: A request sampled on the last beat of a burst starts the new burst in the very next cycle with no idle cycle. A request sampled mid-burst abandons the rest of the current burst.
- R10: A mode write sampled while `busy` is high is ignored, and `mode_err` is high for exactly the following cycle. A mode write sampled while idle takes effect for the beats that follow.
- R11: `busy` is high while a burst is issuing beats or any read-data-valid flag is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load the mode fields below |
| mode_bl | input | 2 | Burst length: 00 = 4, 01 = 8, 1x = full page |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_cl3 | input | 1 | CAS latency: 1 = 3 cycles, 0 = 2 cycles |
| mode_wsingle | input | 1 | 1 = writes are single-beat |
| req | input | 1 | Start a burst |
| req_bank | input | BANK_W | Bank of the new burst |
| req_col | input | COL_W | Start column of the new burst |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| stop | input | 1 | End the running burst |
| col_valid | output | 1 | A beat is issued this cycle |
| col_bank | output | BANK_W | Bank of the current beat |
| col_addr | output | COL_W | Column of the current beat |
| wr_strobe | output | 1 | Write data is taken this cycle |
| rd_valid | output | 1 | Read data is valid this cycle |
| busy | output | 1 | Beats issuing or read data pending |
| mode_err | output | 1 | A mode write was refused last edge |

## Verification
The bench builds the block with its defaults: an 8-bit column, which gives a 256-column row, and a 2-bit bank. This row length puts the full-page wrap from column 0xFF back to 0x00 a few beats away from a start near the top of the row. All four banks are reachable from the vector table. Both CAS latencies and both write policies are switched between vectors. The back-to-back, interrupt, stop-with-request and refused-mode-write cases can each be driven with eleven beats or fewer.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // CAS latencies on offer, in cycles
  localparam int CL_LO = 2;
  localparam int CL_HI = 3;

  // log2 of the two fixed burst lengths
  localparam int BL4_LOG = 2;
  localparam int BL8_LOG = 3;

  typedef enum logic [1:0] {
    BLC_4    = 2'b00,
    BLC_8    = 2'b01,
    BLC_PAGE = 2'b10,
    BLC_PG2  = 2'b11
  } bl_code_e;

  typedef struct packed {
    logic [1:0] bl;
    logic       ilv;
    logic       cl3;
    logic       wsingle;
  } mode_t;

  localparam mode_t MODE_RST = '{bl: BLC_4, ilv: 1'b0, cl3: 1'b1, wsingle: 1'b0};

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  busy,
  input  mode_t mode_in,
  output mode_t mode_q,
  output logic  mode_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      mode_err <= 1'b0;
    end else begin
      mode_err <= wr_en & busy;
      if (wr_en && !busy) mode_q <= mode_in;
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(mode_q)); // R10
  AST_MODE_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> mode_err); // R10
  AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (mode_q == $past(mode_in))); // R10

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [1:0]       bl,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  localparam logic [COL_W-1:0] MASK4 = COL_W'((1 << BL4_LOG) - 1);
  localparam logic [COL_W-1:0] MASK8 = COL_W'((1 << BL8_LOG) - 1);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mask;

  always_comb begin
    sum  = start_col + beat;
    mask = bl[0] ? MASK8 : MASK4;
    if (bl[1])    col = sum;                                  // full page: row wrap
    else if (ilv) col = start_col ^ (beat & mask);            // interleaved
    else          col = (start_col & ~mask) | (sum & mask);   // wrap in block
  end

  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !bl[1]) |-> (((col ^ start_col) & ~MASK8) == '0)); // R3
  AST_BL4_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && bl == 2'b00) |-> (((col ^ start_col) & ~MASK4) == '0)); // R4

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe
  import sbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_beat,
  input  logic cl3,
  output logic rd_valid,
  output logic pending
);

  logic [CL_HI-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[CL_HI-2:0], rd_beat};
  end

  assign rd_valid = cl3 ? pipe[CL_HI-1] : pipe[CL_LO-1];
  assign pending  = cl3 ? (|pipe) : (|pipe[CL_LO-1:0]);

  AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cl3) |-> $past(rd_beat, 3)); // R7
  AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cl3) |-> $past(rd_beat, 2)); // R7

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic              mode_cl3,
  input  logic              mode_wsingle,
  input  logic              req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              stop,
  output logic              col_valid,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              wr_strobe,
  output logic              rd_valid,
  output logic              busy,
  output logic              mode_err
);

  localparam logic [COL_W-1:0] LAST4 = COL_W'((1 << BL4_LOG) - 1);
  localparam logic [COL_W-1:0] LAST8 = COL_W'((1 << BL8_LOG) - 1);

  mode_t             mode_in, mode_q;
  logic              active, is_wr;
  logic [COL_W-1:0]  beat, start_col, last_idx;
  logic [BANK_W-1:0] bank_q;
  logic              single_wr, page, at_last, rd_pending;

  assign mode_in = '{bl: mode_bl, ilv: mode_ilv, cl3: mode_cl3, wsingle: mode_wsingle};

  sbs_mode_reg i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mode_wr),
    .busy     (busy),
    .mode_in  (mode_in),
    .mode_q   (mode_q),
    .mode_err (mode_err)
  );

  // burst length for the running burst
  always_comb begin
    single_wr = is_wr & mode_q.wsingle;
    page      = mode_q.bl[1] & ~single_wr;
    if (single_wr)       last_idx = '0;
    else if (mode_q.bl[0]) last_idx = LAST8;
    else                 last_idx = LAST4;
    at_last = active & ~page & (beat == last_idx);
  end

  // beat control: a request always wins, then stop, then the natural end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      is_wr     <= 1'b0;
      beat      <= '0;
      start_col <= '0;
      bank_q    <= '0;
    end else if (req) begin
      active    <= 1'b1;
      is_wr     <= req_write;
      beat      <= '0;
      start_col <= req_col;
      bank_q    <= req_bank;
    end else if (active) begin
      if (stop || at_last) active <= 1'b0;
      else                 beat   <= beat + 1'b1;
    end
  end

  sbs_col_gen #(.COL_W(COL_W)) i_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (active),
    .start_col (start_col),
    .beat      (beat),
    .bl        (mode_q.bl),
    .ilv       (mode_q.ilv),
    .col       (col_addr)
  );

  sbs_rd_pipe i_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_beat  (active & ~is_wr),
    .cl3      (mode_q.cl3),
    .rd_valid (rd_valid),
    .pending  (rd_pending)
  );

  assign col_valid = active;
  assign col_bank  = bank_q;
  assign wr_strobe = active & is_wr;
  assign busy      = active | rd_pending;

  AST_REQ_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (col_valid && col_addr == $past(req_col) && col_bank == $past(req_bank))); // R2
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !req) |=> !col_valid); // R6
  AST_SINGLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && mode_q.wsingle && !req) |=> !wr_strobe); // R8
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && at_last && req) |=> col_valid); // R9
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid || rd_valid) |-> busy); // R11

endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

  localparam int PERIOD = 10;

  typedef struct packed {
    logic [1:0]      bl;
    logic            ilv;
    logic            cl3;
    logic            ws;
    logic            wr;
    logic [7:0]      col;
    logic [7:0]      stop_n;
    logic [7:0]      len;
    logic [7:0]      tag;
    logic [0:3][7:0] c;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0E, 8'd0, 8'd4, 8'd3, {8'h0E, 8'h0F, 8'h0C, 8'h0D}}, // R3
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0D, 8'd0, 8'd4, 8'd4, {8'h0D, 8'h0C, 8'h0F, 8'h0E}}, // R4
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h25, 8'd0, 8'd8, 8'd3, {8'h25, 8'h26, 8'h27, 8'h20}}, // R3
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 8'd0, 8'd8, 8'd4, {8'h33, 8'h32, 8'h31, 8'h30}}, // R4
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFE, 8'd5, 8'd5, 8'd5, {8'hFE, 8'hFF, 8'h00, 8'h01}}, // R5
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h7A, 8'd4, 8'd4, 8'd5, {8'h7A, 8'h7B, 8'h7C, 8'h7D}}, // R5
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'd0, 8'd1, 8'd8, {8'h11, 8'h00, 8'h00, 8'h00}}, // R8
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'd0, 8'd8, 8'd8, {8'h11, 8'h12, 8'h13, 8'h14}}, // R8
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h40, 8'd2, 8'd2, 8'd6, {8'h40, 8'h41, 8'h00, 8'h00}}, // R6
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 8'd3, 8'd3, 8'd6, {8'h05, 8'h04, 8'h07, 8'h00}}, // R6
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFD, 8'd3, 8'd3, 8'd5, {8'hFD, 8'hFE, 8'hFF, 8'h00}}  // R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0, mode_ilv = 1'b0, mode_cl3 = 1'b0, mode_wsingle = 1'b0;
  logic [1:0] mode_bl = 2'd0;
  logic       req = 1'b0, req_write = 1'b0, stop = 1'b0;
  logic [1:0] req_bank = 2'd0;
  logic [7:0] req_col = 8'd0;
  logic       col_valid, wr_strobe, rd_valid, busy, mode_err;
  logic [1:0] col_bank;
  logic [7:0] col_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] seen [0:15];
  int seen_n;

  always #(PERIOD/2) clk = ~clk;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
    .mode_cl3(mode_cl3), .mode_wsingle(mode_wsingle), .req(req), .req_bank(req_bank),
    .req_col(req_col), .req_write(req_write), .stop(stop), .col_valid(col_valid),
    .col_bank(col_bank), .col_addr(col_addr), .wr_strobe(wr_strobe), .rd_valid(rd_valid),
    .busy(busy), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] bl, input logic ilv, input logic cl3, input logic ws);
    mode_wr = 1'b1; mode_bl = bl; mode_ilv = ilv; mode_cl3 = cl3; mode_wsingle = ws;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit do_mode, input string rq, input logic [1:0] bank);
    int cnt = 0, wrc = 0, rdc = 0, first_rd = -1;
    wait_idle();
    if (do_mode) set_mode(v.bl, v.ilv, v.cl3, v.ws);
    req = 1'b1; req_col = v.col; req_write = v.wr; req_bank = bank;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      req = 1'b0; stop = 1'b0;
      if (col_valid) begin
        if (cnt < 4) chk(col_addr == v.c[cnt], rq, col_addr, v.c[cnt]);
        chk(col_bank == bank, "R2 bank", col_bank, bank);
        if (wr_strobe) wrc++;
        cnt++;
        if (v.stop_n != 0 && cnt == int'(v.stop_n)) stop = 1'b1;
      end
      if (rd_valid) begin
        if (first_rd < 0) first_rd = cyc;
        rdc++;
      end
    end
    chk(cnt == int'(v.len), {rq, " length"}, cnt, v.len);
    chk(wrc == (v.wr ? int'(v.len) : 0), "R8 strobes", wrc, v.wr ? int'(v.len) : 0);
    chk(rdc == (v.wr ? 0 : int'(v.len)), "R7 valid count", rdc, v.wr ? 0 : int'(v.len));
    if (!v.wr) chk(first_rd == (v.cl3 ? 3 : 2), "R7 latency", first_rd, v.cl3 ? 3 : 2);
  endtask

  // first request, then a second one sampled on the edge ending cycle 'at'
  task automatic pair(input logic [7:0] c0, input int at, input logic [7:0] c1, input logic st,
                      input int ncyc);
    seen_n = 0;
    wait_idle();
    req = 1'b1; req_col = c0; req_write = 1'b0; req_bank = 2'd1;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      @(negedge clk);
      req = 1'b0; stop = 1'b0;
      if (col_valid && seen_n < 16) begin seen[seen_n] = col_addr; seen_n++; end
      if (cyc == at) begin req = 1'b1; req_col = c1; stop = st; end
    end
    req = 1'b0; stop = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!col_valid && !wr_strobe && !rd_valid, "R1 outputs", {col_valid, wr_strobe, rd_valid}, 0);
    chk(!busy && !mode_err, "R1 flags", {busy, mode_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !col_valid, "R1 after release", {busy, col_valid}, 0);
    // R1: default mode is 4 beats, sequential, CAS 3
    run_vec('{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h06, 8'd0, 8'd4, 8'd1, {8'h06, 8'h07, 8'h04, 8'h05}},
            1'b0, "R1 default", 2'd2);

    // table walk (R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++)
      run_vec(VEC[i], 1'b1, $sformatf("R%0d vec%0d", VEC[i].tag, i), 2'(i));

    // R10 / R11: mode write during read drain is refused
    wait_idle();
    set_mode(2'd0, 1'b0, 1'b1, 1'b0);
    req = 1'b1; req_col = 8'h20; req_write = 1'b0;
    for (int cyc = 0; cyc < 7; cyc++) begin
      @(negedge clk);
      req = 1'b0;
      if (cyc == 4) begin
        chk(!col_valid && busy, "R11 busy in drain", {col_valid, busy}, 1);
        mode_wr = 1'b1; mode_bl = 2'd1;
      end
      if (cyc == 5) begin
        chk(mode_err == 1'b1, "R10 error pulse", mode_err, 1);
        mode_wr = 1'b0;
      end
      if (cyc == 6) chk(mode_err == 1'b0, "R10 error one cycle", mode_err, 0);
    end
    wait_idle();
    chk(!busy && !rd_valid, "R11 idle after drain", {busy, rd_valid}, 0);
    run_vec('{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h20, 8'd0, 8'd4, 8'd10, {8'h20, 8'h21, 8'h22, 8'h23}},
            1'b0, "R10 mode kept", 2'd0);

    // R9: back-to-back on the last beat, no idle cycle
    wait_idle();
    set_mode(2'd0, 1'b0, 1'b0, 1'b0);
    pair(8'h08, 3, 8'h31, 1'b0, 8);
    chk(seen_n == 8, "R9 no gap", seen_n, 8);
    chk(seen[3] == 8'h0B && seen[4] == 8'h31 && seen[7] == 8'h30, "R9 b2b cols",
        {seen[3], seen[4], seen[7]}, {8'h0B, 8'h31, 8'h30});

    // R9: mid-burst request interrupts
    pair(8'h50, 1, 8'h62, 1'b0, 7);
    chk(seen_n == 6, "R9 interrupt count", seen_n, 6);
    chk(seen[1] == 8'h51 && seen[2] == 8'h62 && seen[5] == 8'h61, "R9 interrupt cols",
        {seen[1], seen[2], seen[5]}, {8'h51, 8'h62, 8'h61});

    // R6: stop sampled with a request does not stop the new burst
    wait_idle();
    set_mode(2'd1, 1'b0, 1'b0, 1'b0);
    pair(8'h70, 2, 8'h90, 1'b1, 12);
    chk(seen_n == 11, "R6 stop with req", seen_n, 11);
    chk(seen[3] == 8'h90 && seen[10] == 8'h97, "R6 new burst cols",
        {seen[3], seen[10]}, {8'h90, 8'h97});

    wait_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule